// File: doc/BRIEF.md
# Two-Wire Serial Command Receiver

This block accepts a single command byte from an external controller over two lines that both rest high: a data line and a clock line. A falling edge on the data line interrupts whatever the host system is doing: playback and instruction execution are told to stop through a one-cycle abort pulse. A new frame then begins. Once the low level on the data line has lasted a full debounce window, the receive shift register and bit counter start from zero. Eight bits then arrive least significant bit first, each one taken on a rising edge of the clock line.

The frame ends when the data line is high after the eighth bit. The byte is then handed to the rest of the chip as an interrupt vector with a one-cycle valid strobe. A busy status pin tells the controller how far the exchange has gone. It is high while idle, low during reception, and high again as an acknowledge when the frame ends. It then goes low while the requested voice plays, until the playback-done input returns the block to idle. Both lines are synchronized into the system clock domain, and all edges are detected there. The system clock must be much faster than the line clock, whose rate lies between 10 kHz and 1 MHz.

Top module: `serial_cmd_rx`

## Requirements
- R1: After reset busy_o is 1, abort_o is 0, vec_valid_o is 0 and vec_o is 0.
- R2: A falling edge of the data line while idle, acknowledging or serving produces a one-cycle abort_o pulse, and busy_o goes to 0.
- R3: If the data line returns high before it has been low for DEB_CYCLES system cycles, the frame is dropped: busy_o returns to 1 and no vector is issued.
- R4: After a debounce is complete, the bit counter and the shift register restart from zero, so a discarded partial frame does not shorten the next one.
- R5: Eight bits are shifted in on rising edges of the clock line, least significant bit first. vec_o carries the assembled byte, with bit 0 being the first bit received.
- R6: A rising edge of the data line while the clock line is high, with fewer than eight bits received, discards the frame: no vector is issued and busy_o returns to 1.
- R7: If the eighth bit is 1, the frame ends at the eighth clock rising edge and busy_o rises without waiting for any further data-line edge.
- R8: If the eighth bit is 0, busy_o stays 0 after the eighth clock edge until the data line rises. Then busy_o goes to 1.
- R9: busy_o stays 1 for ACK_CYCLES cycles after the frame ends. Then vec_valid_o pulses for one cycle with the byte on vec_o, and busy_o is 0 from that cycle on.
- R10: play_done_i while serving returns the block to idle with busy_o at 1. play_done_i at any other time has no effect.
- R11: When a clock-line rise and a data-line rise are seen in the same cycle during reception, the clock edge wins: a 1 bit is captured and the frame continues.
- R12: A data-line falling edge while serving aborts the playback and starts a new frame, which is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_line_i | input | 1 | Serial data line, idles high |
| clk_line_i | input | 1 | Serial clock line, idles high |
| play_done_i | input | 1 | Requested playback has finished |
| busy_o | output | 1 | Busy status to the controller |
| abort_o | output | 1 | One-cycle request to stop playback and execution |
| vec_valid_o | output | 1 | One-cycle strobe, vec_o holds a new vector |
| vec_o | output | DATA_W | Received interrupt vector |

## Verification
Two events can land in the same system cycle: a data-line rise, which in reception may end or discard the frame, and a clock-line rise, which shifts in a bit. The bench provokes this by releasing both lines on the same clock step during a bit whose previous value was 0. With the clock line high at that moment, the data-line rise alone would discard the frame. A correct block must capture a 1 and go on to deliver the complete byte 0x5A. A discarded frame (busy high with no vector) or a wrong vector value reports the fault.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEB,
    ST_RECV,
    ST_TAIL,
    ST_ACK,
    ST_SERVE
  } scr_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar i = 0; i < W; i++) begin : g_line
    logic ff1_q, ff2_q;
    // lines idle high, so reset to 1 to avoid a false falling edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q <= 1'b1;
        ff2_q <= 1'b1;
      end else begin
        ff1_q <= async_i[i];
        ff2_q <= ff1_q;
      end
    end
    assign sync_o[i] = ff2_q;
  end
endmodule

// File: rtl/deb_timer.sv
module deb_timer #(
  parameter int unsigned CYCLES = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  p_deb_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/shift_rx.sv
module shift_rx #(
  parameter int unsigned W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       shift_i,
  input  logic                       bit_i,
  output logic [W-1:0]               data_o,
  output logic [$clog2(W+1)-1:0]     cnt_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift_i && cnt_q != FULL) begin
      sr_q  <= {bit_i, sr_q[W-1:1]};  // LSB first
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign data_o = sr_q;
  assign cnt_o  = cnt_q;

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import scr_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned DEB_CYCLES = 32,
  parameter int unsigned ACK_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              data_line_i,
  input  logic              clk_line_i,
  input  logic              play_done_i,
  output logic              busy_o,
  output logic              abort_o,
  output logic              vec_valid_o,
  output logic [DATA_W-1:0] vec_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);
  localparam int unsigned ACK_W = $clog2(ACK_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [ACK_W-1:0] ACK_LAST = ACK_W'(ACK_CYCLES - 1);

  scr_state_e state_q, state_n;
  logic [1:0] lines_s;
  logic d_s, c_s, d_prev_q, c_prev_q;
  logic d_fall, d_rise, c_rise;
  logic deb_done, clr, shift, abort_n, vec_n;
  logic [DATA_W-1:0] sr;
  logic [CNT_W-1:0]  bit_cnt;
  logic [ACK_W-1:0]  ack_q;

  line_sync #(.W(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({data_line_i, clk_line_i}),
    .sync_o  (lines_s)
  );

  assign d_s = lines_s[1];
  assign c_s = lines_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_prev_q <= 1'b1;
      c_prev_q <= 1'b1;
    end else begin
      d_prev_q <= d_s;
      c_prev_q <= c_s;
    end
  end

  assign d_fall = d_prev_q && !d_s;
  assign d_rise = !d_prev_q && d_s;
  assign c_rise = !c_prev_q && c_s;

  deb_timer #(.CYCLES(DEB_CYCLES)) u_deb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  ((state_q == ST_DEB) && !d_s),
    .done_o (deb_done)
  );

  shift_rx #(.W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clr),
    .shift_i (shift),
    .bit_i   (d_s),
    .data_o  (sr),
    .cnt_o   (bit_cnt)
  );

  always_comb begin
    state_n = state_q;
    abort_n = 1'b0;
    vec_n   = 1'b0;
    clr     = 1'b0;
    shift   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (d_fall) begin
        state_n = ST_DEB;
        abort_n = 1'b1;
      end
      ST_DEB: begin
        if (d_s) state_n = ST_IDLE;             // glitch, drop frame
        else if (deb_done) begin
          clr     = 1'b1;
          state_n = ST_RECV;
        end
      end
      ST_RECV: begin
        if (c_rise) begin                       // clock edge beats end marker
          shift = 1'b1;
          if (bit_cnt == LAST_BIT) state_n = d_s ? ST_ACK : ST_TAIL;
        end else if (d_rise && c_s) begin
          state_n = ST_IDLE;                    // short frame
        end
      end
      ST_TAIL: if (d_rise) state_n = ST_ACK;
      ST_ACK: begin
        if (d_fall) begin
          state_n = ST_DEB;
          abort_n = 1'b1;
        end else if (ack_q == ACK_LAST) begin
          state_n = ST_SERVE;
          vec_n   = 1'b1;
        end
      end
      ST_SERVE: begin
        if (d_fall) begin
          state_n = ST_DEB;
          abort_n = 1'b1;
        end else if (play_done_i) begin
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ack_q       <= '0;
      abort_o     <= 1'b0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      state_q     <= state_n;
      ack_q       <= (state_q == ST_ACK) ? ack_q + 1'b1 : '0;
      abort_o     <= abort_n;
      vec_valid_o <= vec_n;
      if (vec_n) vec_o <= sr;
    end
  end

  assign busy_o = (state_q == ST_IDLE) || (state_q == ST_ACK);

  p_abort_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  p_abort_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !busy_o);
  p_vec_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);
  p_vec_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> !busy_o);
  p_ack_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vec_valid_o) |-> $past(busy_o));
endmodule

// File: tb/serial_cmd_rx_test.sv
module serial_cmd_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEB        = 32;
  localparam int H          = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_line = 1'b1;
  logic clk_line = 1'b1;
  logic play_done = 1'b0;
  logic busy, abort_p, vec_valid;
  logic [7:0] vec;

  int checks = 0;
  int errors = 0;
  int vec_cnt = 0;
  int abort_cnt = 0;
  logic [7:0] last_vec = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cmd_rx uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .data_line_i (data_line),
    .clk_line_i  (clk_line),
    .play_done_i (play_done),
    .busy_o      (busy),
    .abort_o     (abort_p),
    .vec_valid_o (vec_valid),
    .vec_o       (vec)
  );

  always @(posedge clk) begin
    if (vec_valid) begin
      vec_cnt  <= vec_cnt + 1;
      last_vec <= vec;
    end
    if (abort_p) abort_cnt <= abort_cnt + 1;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_frame();
    int a0 = abort_cnt;
    data_line = 1'b0;
    wait_cyc(4);
    check(abort_cnt == a0 + 1, "R2 abort pulse", abort_cnt, a0 + 1);
    check(busy == 1'b0, "R2 busy low on start", busy, 0);
    wait_cyc(DEB + 4);
  endtask

  // shifts n bits; returns right after the last clock rise
  task automatic send_bits(input logic [7:0] b, input int n, input int coincide);
    for (int i = 0; i < n; i++) begin
      clk_line = 1'b0;
      wait_cyc(H);
      if (i == coincide) begin
        data_line = b[i];
        clk_line  = 1'b1;
      end else begin
        data_line = b[i];
        wait_cyc(H);
        clk_line = 1'b1;
      end
      if (i != n - 1) wait_cyc(H);
    end
  endtask

  task automatic finish_and_serve(input logic [7:0] b, input string tag, input bit done);
    int v0 = vec_cnt;
    if (b[7]) begin
      wait_cyc(5);
      check(busy == 1'b1, "R7 busy rises on last clock edge", busy, 1);
      check(vec_cnt == v0, "R9 no vector during acknowledge", vec_cnt, v0);
    end else begin
      wait_cyc(5);
      check(busy == 1'b0, "R8 busy low until data rises", busy, 0);
      wait_cyc(20);
      check(busy == 1'b0 && vec_cnt == v0, "R8 still waiting", busy, 0);
      data_line = 1'b1;
      wait_cyc(5);
      check(busy == 1'b1, "R8 busy rises after data rise", busy, 1);
    end
    wait_cyc(6);
    check(vec_cnt == v0 + 1, {tag, " vector strobe count"}, vec_cnt, v0 + 1);
    check(last_vec == b, {tag, " vector value"}, last_vec, b);
    check(busy == 1'b0, "R9 busy low while serving", busy, 0);
    if (done) begin
      wait_cyc(10);
      check(busy == 1'b0, "R9 busy held low until done", busy, 0);
      play_done = 1'b1;
      wait_cyc(1);
      play_done = 1'b0;
      wait_cyc(3);
      check(busy == 1'b1, "R10 done returns to idle", busy, 1);
    end
  endtask

  task automatic t_reset();
    check(busy == 1'b1, "R1 busy after reset", busy, 1);
    check(abort_p == 1'b0, "R1 abort after reset", abort_p, 0);
    check(vec_valid == 1'b0, "R1 valid after reset", vec_valid, 0);
    check(vec == 8'h00, "R1 vector after reset", vec, 0);
  endtask

  task automatic t_frame(input logic [7:0] b);
    start_frame();
    send_bits(b, 8, -1);
    finish_and_serve(b, "R5", 1'b1);
  endtask

  task automatic t_glitch();
    int v0 = vec_cnt;
    int a0 = abort_cnt;
    data_line = 1'b0;
    wait_cyc(10);
    data_line = 1'b1;
    wait_cyc(6);
    check(busy == 1'b1, "R3 glitch back to idle", busy, 1);
    check(abort_cnt == a0 + 1, "R3 abort still pulsed", abort_cnt, a0 + 1);
    wait_cyc(20);
    check(vec_cnt == v0, "R3 no vector from glitch", vec_cnt, v0);
  endtask

  task automatic t_short_then_full();
    int v0 = vec_cnt;
    start_frame();
    send_bits(8'b0000_0011, 3, -1);
    wait_cyc(H);
    data_line = 1'b1;
    wait_cyc(6);
    check(busy == 1'b1, "R6 short frame dropped", busy, 1);
    wait_cyc(20);
    check(vec_cnt == v0, "R6 no vector from short frame", vec_cnt, v0);
    start_frame();
    send_bits(8'h22, 8, -1);
    finish_and_serve(8'h22, "R4", 1'b1);
  endtask

  task automatic t_coincide();
    start_frame();
    send_bits(8'h5A, 8, 1);
    finish_and_serve(8'h5A, "R11", 1'b1);
  endtask

  task automatic t_done_ignored();
    int v0 = vec_cnt;
    play_done = 1'b1;
    wait_cyc(3);
    play_done = 1'b0;
    wait_cyc(3);
    check(busy == 1'b1 && vec_cnt == v0, "R10 done ignored in idle", busy, 1);
  endtask

  task automatic t_abort_serve();
    start_frame();
    send_bits(8'h81, 8, -1);
    finish_and_serve(8'h81, "R12 first", 1'b0);
    start_frame();
    send_bits(8'hC3, 8, -1);
    finish_and_serve(8'hC3, "R12 second", 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(3);
    t_frame(8'hA5);
    t_frame(8'h22);
    t_frame(8'h00);
    t_frame(8'hFF);
    t_glitch();
    t_short_then_full();
    t_coincide();
    t_done_ignored();
    t_abort_serve();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule